// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small in-order CPU core. It collects interrupt sources of two kinds. Edge-type sources latch a pending flag on a one-cycle event pulse. Level-type sources have no flag and request only while their input is held high. Every source is gated by its own enable bit and by a single global enable bit. The lowest-numbered eligible source wins, and its vector address is presented to the core as a registered request.

The core talks to the controller with a small handshake. `irq_ack` reports interrupt entry. `reti` reports return from interrupt, `instr_retire` reports each completed main-program instruction, and `gie_set` and `gie_clr` are the set and clear of the global enable. After a return, the controller lets exactly one instruction retire before it asks again. A global clear blocks requests in the very cycle it is issued. `vec_sel` moves the vector table from address zero to a boot base. Each table slot is two words wide, and slot zero belongs to reset.

The control is a three-state machine:
- `ST_IDLE` waits for a request.
- `ST_REQ` holds `irq_req` and the vector.
- `ST_HOLD` waits out the one-instruction delay after a return.

Its transitions are:
- IDLE->REQ (grant): the global enable is on, no clear is issued and some source is eligible.
- IDLE->HOLD (return): `reti` arrives in IDLE.
- REQ->IDLE (entry): `irq_ack` arrives.
- REQ->IDLE (withdraw): `gie_clr` arrives.
- REQ->HOLD (return): `reti` arrives without `irq_ack`.
- HOLD->IDLE (release): `instr_retire` arrives.

Top module: `irq_vector_ctrl`

## Requirements
- R1: An edge source (indices 0..3 by default) sets its bit of `flags` on the cycle after `src_event` is high. A level source (indices 4..7) never sets a flag. All flags, the global enable and `irq_req` are zero after reset.
- R2: A source can be granted only while its enable bit (written by `src_en_wr`/`src_en_data`) and `gie_en` are both one.
- R3: Among eligible sources, the lowest index is granted.
- R4: `irq_vec` equals base + 2*(index+1). The base is 0 when `vec_sel` is 0 and BOOT_BASE (default 0xC00) when it is 1, sampled at grant.
- R5: `irq_req` rises one cycle after a grant. `irq_req` and `irq_vec` then stay unchanged until `irq_ack`, `gie_clr` or `reti`.
- R6: `irq_ack` during `irq_req` clears `gie_en` and clears the flag of the granted edge source on the next cycle.
- R7: Writing `flag_clr_wr` with a one in a bit of `flag_clr_data` clears that flag. An event in the same cycle wins and the flag stays set.
- R8: A flag set while its enable or `gie_en` is off stays pending and is granted once both are on.
- R9: A level source that drops before it is enabled causes no request and leaves no flag.
- R10: `reti` sets `gie_en`. No request is raised after `reti` until one `instr_retire` has been seen.
- R11: `gie_clr` clears `gie_en` at once. No request appears on the next cycle, even when an eligible source arrives in the same cycle. A held request is withdrawn and its flag stays set.
- R12: `gie_set` sets `gie_en` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_event | input | N | Event pulses (edge sources) or held conditions (level sources) |
| src_en_wr | input | 1 | Write strobe for the enable register |
| src_en_data | input | N | New enable bits |
| flag_clr_wr | input | 1 | Write-one-to-clear strobe for flags |
| flag_clr_data | input | N | Flags to clear |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable (immediate) |
| reti | input | 1 | Return from interrupt |
| instr_retire | input | 1 | Core completed one instruction |
| vec_sel | input | 1 | 0: table at zero, 1: table at boot base |
| irq_ack | input | 1 | Core enters the presented interrupt |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | ADDR_W | Vector address of the request |
| gie_en | output | 1 | Global enable state |
| flags | output | N | Pending flags of edge sources |

## Verification
Some rules are checked by the assertions on every cycle. These are the link between a request and the global enable, holding the request and vector stable, and entry clearing the enable. They also cover return setting it, no request in the cycle after a return or a clear, and write-one-to-clear. Other behaviour only the bench scenarios can show. That covers the priority order across source mixes, the vector values under both table bases, and flags staying pending while disabled. It also covers vanished level sources, the one-instruction delay being released by a retire, and an event beating a clear.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_HOLD = 2'd2
    } ivc_state_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int          N         = 8,
    parameter logic [N-1:0] EDGE_MASK = 8'h0F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_event,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_data,
    input  logic [N-1:0] take_vec,
    output logic [N-1:0] flags,
    output logic [N-1:0] pending
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_src
            if (EDGE_MASK[g]) begin : g_edge
                logic flag_q;
                logic clr_hit;
                assign clr_hit = (clr_wr & clr_data[g]) | take_vec[g];
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        flag_q <= 1'b0;
                    else
                        flag_q <= src_event[g] | (flag_q & ~clr_hit);
                end
                assign flags[g]   = flag_q;
                assign pending[g] = flag_q;
            end else begin : g_level
                assign flags[g]   = 1'b0;
                assign pending[g] = src_event[g];
            end
        end
    endgenerate
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
    parameter int               N         = 8,
    parameter int               IDX_W     = $clog2(N),
    parameter int               ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 12'hC00
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              sel,
    output logic [ADDR_W-1:0] vec
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] slot;
    always_comb begin
        base = sel ? BOOT_BASE : '0;
        slot = ADDR_W'(idx) + ADDR_W'(1);
        vec  = base + (slot << 1);
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int                N         = 8,
    parameter int                ADDR_W    = 12,
    parameter logic [N-1:0]      EDGE_MASK = 8'h0F,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 12'hC00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      src_event,
    input  logic              src_en_wr,
    input  logic [N-1:0]      src_en_data,
    input  logic              flag_clr_wr,
    input  logic [N-1:0]      flag_clr_data,
    input  logic              gie_set,
    input  logic              gie_clr,
    input  logic              reti,
    input  logic              instr_retire,
    input  logic              vec_sel,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [ADDR_W-1:0] irq_vec,
    output logic              gie_en,
    output logic [N-1:0]      flags
);
    import ivc_pkg::*;

    localparam int IDX_W = $clog2(N);

    ivc_state_e        state_q, state_d;
    logic [N-1:0]      en_q;
    logic              gie_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] vec_q;
    logic [N-1:0]      pending;
    logic [N-1:0]      eligible;
    logic              win_any;
    logic [IDX_W-1:0]  win_idx;
    logic [ADDR_W-1:0] win_vec;
    logic              take;
    logic              grant;
    logic [N-1:0]      take_vec;

    irq_flag_bank #(.N(N), .EDGE_MASK(EDGE_MASK)) flag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_event(src_event),
        .clr_wr   (flag_clr_wr),
        .clr_data (flag_clr_data),
        .take_vec (take_vec),
        .flags    (flags),
        .pending  (pending)
    );

    assign eligible = pending & en_q;

    irq_prio_sel #(.N(N), .IDX_W(IDX_W)) prio_i (
        .req(eligible),
        .any(win_any),
        .idx(win_idx)
    );

    irq_vec_gen #(.N(N), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) vgen_i (
        .idx(win_idx),
        .sel(vec_sel),
        .vec(win_vec)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        grant   = 1'b0;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (reti) begin
                    state_d = ST_HOLD;
                end else if (gie_q && !gie_clr && win_any) begin
                    state_d = ST_REQ;
                    grant   = 1'b1;
                end
            end
            ST_REQ: begin
                if (irq_ack) begin
                    state_d = ST_IDLE;
                    take    = 1'b1;
                end else if (reti) begin
                    state_d = ST_HOLD;
                end else if (gie_clr) begin
                    state_d = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (instr_retire && !reti)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign take_vec = take ? (N'(1) << idx_q) : '0;

    // State and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            en_q    <= '0;
            gie_q   <= 1'b0;
            idx_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (src_en_wr)
                en_q <= src_en_data;
            if (take || gie_clr)
                gie_q <= 1'b0;
            else if (gie_set || reti)
                gie_q <= 1'b1;
            if (grant) begin
                idx_q <= win_idx;
                vec_q <= win_vec;
            end
        end
    end

    // Outputs
    always_comb begin
        irq_req = (state_q == ST_REQ);
        irq_vec = vec_q;
        gie_en  = gie_q;
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int N      = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      src_event,
    input logic              flag_clr_wr,
    input logic [N-1:0]      flag_clr_data,
    input logic              gie_clr,
    input logic              reti,
    input logic              irq_ack,
    input logic              irq_req,
    input logic [ADDR_W-1:0] irq_vec,
    input logic              gie_en,
    input logic [N-1:0]      flags
);
    // R2
    req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie_en);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack && !gie_clr && !reti) |=> (irq_req && $stable(irq_vec)));

    // R6
    entry_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !gie_en);

    // R10
    reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !gie_clr && !(irq_req && irq_ack)) |=> gie_en);

    // R10
    hold_after_reti_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> !irq_req);

    // R11
    cli_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_clr && !(irq_req && irq_ack)) |=> (!irq_req && !gie_en));

    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr_wr |=> ((flags & $past(flag_clr_data) & ~$past(src_event)) == '0));

    // R4
    vec_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[0] == 1'b0));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N(N), .ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_event    (src_event),
    .flag_clr_wr  (flag_clr_wr),
    .flag_clr_data(flag_clr_data),
    .gie_clr      (gie_clr),
    .reti         (reti),
    .irq_ack      (irq_ack),
    .irq_req      (irq_req),
    .irq_vec      (irq_vec),
    .gie_en       (gie_en),
    .flags        (flags)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
    localparam int N = 8;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] BOOT = 12'hC00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src_event = '0;
    logic src_en_wr = 1'b0;
    logic [N-1:0] src_en_data = '0;
    logic flag_clr_wr = 1'b0;
    logic [N-1:0] flag_clr_data = '0;
    logic gie_set = 1'b0, gie_clr = 1'b0, reti = 1'b0, instr_retire = 1'b0;
    logic vec_sel = 1'b0, irq_ack = 1'b0;
    logic irq_req, gie_en;
    logic [ADDR_W-1:0] irq_vec;
    logic [N-1:0] flags;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_event(src_event),
        .src_en_wr(src_en_wr), .src_en_data(src_en_data),
        .flag_clr_wr(flag_clr_wr), .flag_clr_data(flag_clr_data),
        .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
        .instr_retire(instr_retire), .vec_sel(vec_sel), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vec(irq_vec), .gie_en(gie_en), .flags(flags)
    );

    // {enable, edge pulse, level hold, vec_sel, expected index}
    localparam logic [27:0] VEC_TBL [0:5] = '{
        {8'hFF, 8'h04, 8'h00, 1'b0, 3'd2},
        {8'hFF, 8'h0A, 8'h00, 1'b0, 3'd1},
        {8'hFE, 8'h03, 8'h00, 1'b0, 3'd1},
        {8'hFF, 8'h00, 8'h30, 1'b0, 3'd4},
        {8'hFF, 8'h08, 8'h80, 1'b1, 3'd3},
        {8'h80, 8'h00, 8'hC0, 1'b1, 3'd7}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_vec(input int idx, input logic sel);
        return (sel ? BOOT : '0) + ADDR_W'(2 * (idx + 1));
    endfunction

    task automatic finish_service();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        reti = 1'b1; step(); reti = 1'b0;
        instr_retire = 1'b1; step(); instr_retire = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 reset req", 32'(irq_req), 0);
        chk("R1 reset gie", 32'(gie_en), 0);
        chk("R1 reset flags", 32'(flags), 0);

        // Table walk: R2 R3 R4 R1 R6
        for (int e = 0; e < 6; e++) begin
            logic [7:0] en, pulse, lvl;
            logic vs;
            int ix;
            {en, pulse, lvl, vs} = VEC_TBL[e][27:3];
            ix = int'(VEC_TBL[e][2:0]);
            gie_clr = 1'b1; flag_clr_wr = 1'b1; flag_clr_data = '1;
            src_en_wr = 1'b1; src_en_data = en; vec_sel = vs;
            step();
            gie_clr = 1'b0; flag_clr_wr = 1'b0; src_en_wr = 1'b0;
            src_event = pulse | lvl;
            step();
            src_event = lvl;
            chk("R1 edge flags latched", 32'(flags), 32'(pulse & 8'h0F));
            gie_set = 1'b1; step(); gie_set = 1'b0;
            chk("R12 gie set", 32'(gie_en), 1);
            step();
            chk("R3 req raised", 32'(irq_req), 1);
            chk("R4 vector", 32'(irq_vec), 32'(exp_vec(ix, vs)));
            irq_ack = 1'b1; step(); irq_ack = 1'b0;
            chk("R6 gie cleared", 32'(gie_en), 0);
            chk("R6 taken flag cleared", 32'(flags[ix]), 0);
            src_event = '0;
            reti = 1'b1; step(); reti = 1'b0;
            instr_retire = 1'b1; step(); instr_retire = 1'b0;
        end

        // R9 level drops before enable
        gie_clr = 1'b1; flag_clr_wr = 1'b1; flag_clr_data = '1;
        src_en_wr = 1'b1; src_en_data = 8'hFF; vec_sel = 1'b0;
        step();
        gie_clr = 1'b0; flag_clr_wr = 1'b0; src_en_wr = 1'b0;
        src_event = 8'h20; step(); step(); src_event = '0; step();
        gie_set = 1'b1; step(); gie_set = 1'b0; step(); step();
        chk("R9 no request", 32'(irq_req), 0);
        chk("R9 no flag", 32'(flags), 0);

        // R8 pending while disabled
        gie_clr = 1'b1; src_en_wr = 1'b1; src_en_data = 8'h00; step();
        gie_clr = 1'b0; src_en_wr = 1'b0;
        src_event = 8'h01; step(); src_event = '0;
        chk("R8 flag pending", 32'(flags[0]), 1);
        gie_set = 1'b1; step(); gie_set = 1'b0; step(); step();
        chk("R2 no req when disabled", 32'(irq_req), 0);
        src_en_wr = 1'b1; src_en_data = 8'h01; step(); src_en_wr = 1'b0;
        step();
        chk("R8 serviced once enabled", 32'(irq_req), 1);
        chk("R8 vector", 32'(irq_vec), 32'(exp_vec(0, 1'b0)));
        finish_service();

        // R10 one-instruction delay after return
        gie_clr = 1'b1; src_en_wr = 1'b1; src_en_data = 8'hFF; step();
        gie_clr = 1'b0; src_en_wr = 1'b0;
        src_event = 8'h05; step(); src_event = '0;
        gie_set = 1'b1; step(); gie_set = 1'b0; step();
        chk("R3 idx0 first", 32'(irq_vec), 32'(exp_vec(0, 1'b0)));
        irq_ack = 1'b1; step(); irq_ack = 1'b0; step();
        chk("R6 no req after entry", 32'(irq_req), 0);
        reti = 1'b1; step(); reti = 1'b0;
        chk("R10 gie set by reti", 32'(gie_en), 1);
        for (int k = 0; k < 3; k++) begin
            chk("R10 held off", 32'(irq_req), 0);
            step();
        end
        instr_retire = 1'b1; step(); instr_retire = 1'b0; step();
        chk("R10 released", 32'(irq_req), 1);
        chk("R10 vector", 32'(irq_vec), 32'(exp_vec(2, 1'b0)));

        // R11 withdraw
        gie_clr = 1'b1; step(); gie_clr = 1'b0;
        chk("R11 withdrawn", 32'(irq_req), 0);
        chk("R11 flag kept", 32'(flags[2]), 1);

        // R11 same-cycle event and clear
        flag_clr_wr = 1'b1; flag_clr_data = '1; step(); flag_clr_wr = 1'b0;
        gie_set = 1'b1; step(); gie_set = 1'b0;
        src_event = 8'h10; gie_clr = 1'b1; step(); gie_clr = 1'b0;
        chk("R11 blocked", 32'(irq_req), 0);
        step();
        chk("R11 still blocked", 32'(irq_req), 0);
        src_event = '0;

        // R7 W1C and event priority
        flag_clr_wr = 1'b1; flag_clr_data = 8'h08; src_event = 8'h08; step();
        flag_clr_wr = 1'b0; src_event = '0;
        chk("R7 event wins", 32'(flags), 32'h08);
        flag_clr_wr = 1'b1; step(); flag_clr_wr = 1'b0;
        chk("R7 cleared", 32'(flags), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule